// File: doc/BRIEF.md
# Look-Ahead Round-Robin Issue Scheduler with Lane Wake Control

This block picks one ready warp per cycle in circular order and, alongside that pick, works out which two warps it would choose in the two following cycles if the ready set stayed as it is. The three picks form a three-slot window. The active-thread mask of each chosen warp becomes the lane-busy mask for that slot. Lanes that divergence has switched off in a warp's mask therefore show as idle in that slot.

Each execution lane reports its present power mode. A lane in a reduced-supply or gated mode needs one, two or three cycles to return to full power. The block raises that lane's wake request early enough that the lane is ready when a warp in the window uses it. A warp issued in slot d executes one cycle after that slot. The look-ahead picks are worked out again every cycle from the current pointer and ready bits, so a change in readiness takes effect at once.

Top module: `peek_rr_sched`

## Requirements
- R1: After reset the search pointer is warp 0, so the first issue goes to the lowest-numbered ready warp.
- R2: Each cycle the issued warp is the first ready warp at or after the pointer in circular index order. After a valid issue the pointer moves to one past the issued warp, wrapping from the last warp to warp 0. Without an issue the pointer holds.
- R3: When no warp is ready, issue_valid and both look-ahead valid flags are 0. All warp index outputs read 0, all three busy masks are zero and no lane wake is raised.
- R4: la1_warp is the first ready warp strictly after the issued warp in circular order, and la2_warp is the first one strictly after la1_warp. With a single ready warp, all three slots name that warp.
- R5: busy_now, busy_nx1 and busy_nx2 equal the active masks of the warps in slots 0, 1 and 2. Warp w's mask is warp_mask[w*LANES +: LANES]. Lanes that are 0 in the mask stay 0 in the busy mask.
- R6: Lane l's power mode is lane_mode[2*l +: 2] with 0 = full power (no wake time), 1 = light voltage reduction (1 cycle), 2 = deep voltage reduction (2 cycles) and 3 = power gated (3 cycles).
- R7: lane_wake[l] is 1 exactly when lane l is busy in some slot d with d smaller than the wake time of its mode. A lane at full power never gets a wake request.
- R8: The look-ahead picks use the current ready bits and pointer each cycle. After the ready set changes, the issue and both look-ahead slots follow the new set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | WARPS | Per-warp ready bits |
| warp_mask | input | WARPS*LANES | Active-thread masks, warp w at [w*LANES +: LANES] |
| lane_mode | input | 2*LANES | Per-lane power mode, lane l at [2*l +: 2] |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | clog2(WARPS) | Warp issued this cycle |
| la1_valid | output | 1 | Slot 1 prediction valid |
| la1_warp | output | clog2(WARPS) | Warp predicted for the next cycle |
| la2_valid | output | 1 | Slot 2 prediction valid |
| la2_warp | output | clog2(WARPS) | Warp predicted two cycles ahead |
| busy_now | output | LANES | Lanes used by the slot 0 warp |
| busy_nx1 | output | LANES | Lanes used by the slot 1 warp |
| busy_nx2 | output | LANES | Lanes used by the slot 2 warp |
| lane_wake | output | LANES | Per-lane early wake request |

## Verification
The bench wraps the pointer past the last warp. A design that failed to wrap would stall on high warps or skip warp 0. With a single ready warp, a look-ahead that excluded the issued warp would report an empty window. A warp with an all-zero mask must yield an idle busy mask even though it was issued. In the wake tests every mode sits beside busy bits in each slot, so a lead one cycle too short or too long shows up as a missing or extra wake on gated and deep-scaled lanes. The ready set also changes mid-run to catch look-ahead picks kept stale from an earlier cycle.

// File: rtl/peek_sched_pkg.sv
package peek_sched_pkg;

    localparam int WINDOW = 3;

    typedef enum logic [1:0] {
        PM_FULL  = 2'd0,
        PM_LIGHT = 2'd1,
        PM_DEEP  = 2'd2,
        PM_GATED = 2'd3
    } pwr_mode_e;

    // cycles a lane needs to regain full supply from a given mode
    function automatic int wake_lead(pwr_mode_e m);
        case (m)
            PM_LIGHT: return 1;
            PM_DEEP:  return 2;
            PM_GATED: return 3;
            default:  return 0;
        endcase
    endfunction

    function automatic int wrap_inc(int v, int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/ps_rr_pick.sv
module ps_rr_pick #(
    parameter int NW = 8,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic [NW-1:0] req,
    input  logic [IW-1:0] start,
    output logic          vld,
    output logic [IW-1:0] idx
);
    logic [IW-1:0] cand;

    // scan from the farthest offset down so the nearest hit wins
    always_comb begin
        vld  = 1'b0;
        idx  = '0;
        cand = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            cand = IW'((int'(start) + i) % NW);
            if (req[cand]) begin
                vld = 1'b1;
                idx = cand;
            end
        end
    end
endmodule

// File: rtl/ps_lane_waker.sv
module ps_lane_waker
    import peek_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pwr_mode_e         mode,
    input  logic [WINDOW-1:0] busy,
    output logic              wake
);
    always_comb begin
        wake = 1'b0;
        for (int d = 0; d < WINDOW; d++) begin
            if (busy[d] && d < wake_lead(mode)) wake = 1'b1;
        end
    end

    // R7: a lane already at full supply is never woken
    a_r7_full_no_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_FULL) |-> !wake);

    // R7: a gated lane busy at the far end of the window is woken
    a_r7_gated_lead: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_GATED && busy[WINDOW-1]) |-> wake);
endmodule

// File: rtl/peek_rr_sched.sv
module peek_rr_sched
    import peek_sched_pkg::*;
#(
    parameter int WARPS = 8,
    parameter int LANES = 32,
    localparam int IW = (WARPS > 1) ? $clog2(WARPS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WARPS-1:0]   warp_ready,
    input  logic [WARPS*LANES-1:0] warp_mask,
    input  logic [2*LANES-1:0] lane_mode,
    output logic               issue_valid,
    output logic [IW-1:0]      issue_warp,
    output logic               la1_valid,
    output logic [IW-1:0]      la1_warp,
    output logic               la2_valid,
    output logic [IW-1:0]      la2_warp,
    output logic [LANES-1:0]   busy_now,
    output logic [LANES-1:0]   busy_nx1,
    output logic [LANES-1:0]   busy_nx2,
    output logic [LANES-1:0]   lane_wake
);
    logic [IW-1:0]    ptr_q;
    logic [WINDOW-1:0] s_vld;
    logic [IW-1:0]    s_start [WINDOW];
    logic [IW-1:0]    s_idx   [WINDOW];
    logic [LANES-1:0] s_busy  [WINDOW];
    logic [IW-1:0]    ptr_after;

    assign ptr_after = IW'(wrap_inc(int'(s_idx[0]), WARPS));

    for (genvar s = 0; s < WINDOW; s++) begin : g_slot
        if (s == 0) begin : g_head
            assign s_start[s] = ptr_q;
        end else begin : g_tail
            assign s_start[s] = IW'(wrap_inc(int'(s_idx[s-1]), WARPS));
        end

        ps_rr_pick #(.NW(WARPS)) u_pick (
            .req   (warp_ready),
            .start (s_start[s]),
            .vld   (s_vld[s]),
            .idx   (s_idx[s])
        );

        assign s_busy[s] = s_vld[s] ? warp_mask[int'(s_idx[s])*LANES +: LANES] : '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ps_lane_waker u_wake (
            .clk  (clk),
            .rst  (rst),
            .mode (pwr_mode_e'(lane_mode[2*l +: 2])),
            .busy ({s_busy[2][l], s_busy[1][l], s_busy[0][l]}),
            .wake (lane_wake[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           ptr_q <= '0;
        else if (s_vld[0]) ptr_q <= ptr_after;
    end

    assign issue_valid = s_vld[0];
    assign issue_warp  = s_idx[0];
    assign la1_valid   = s_vld[1];
    assign la1_warp    = s_idx[1];
    assign la2_valid   = s_vld[2];
    assign la2_warp    = s_idx[2];
    assign busy_now    = s_busy[0];
    assign busy_nx1    = s_busy[1];
    assign busy_nx2    = s_busy[2];

    // R2: only a ready warp is issued
    a_r2_issue_ready: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> warp_ready[issue_warp]);

    // R3: an empty slot 0 leaves every lane idle and unwoken
    a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (busy_now == '0 && busy_nx1 == '0 && busy_nx2 == '0 && lane_wake == '0));

    // R4: the next-cycle prediction comes true when readiness holds
    a_r4_la1_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(issue_valid) && warp_ready == $past(warp_ready))
            |-> issue_warp == $past(la1_warp));

    // R4: a non-empty ready set fills the whole window
    a_r4_window_full: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (la1_valid && la2_valid));
endmodule

// File: tb/peek_rr_sched_tb.sv
module peek_rr_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int L  = 32;
    localparam int IW = 3;

    logic             clk;
    logic             rst;
    logic [W-1:0]     warp_ready;
    logic [W*L-1:0]   warp_mask;
    logic [2*L-1:0]   lane_mode;
    logic             issue_valid, la1_valid, la2_valid;
    logic [IW-1:0]    issue_warp, la1_warp, la2_warp;
    logic [L-1:0]     busy_now, busy_nx1, busy_nx2, lane_wake;

    int total = 0;
    int bad   = 0;
    int mptr  = 0;
    bit done  = 0;

    peek_rr_sched #(.WARPS(W), .LANES(L)) u_dut (
        .clk(clk), .rst(rst), .warp_ready(warp_ready), .warp_mask(warp_mask),
        .lane_mode(lane_mode), .issue_valid(issue_valid), .issue_warp(issue_warp),
        .la1_valid(la1_valid), .la1_warp(la1_warp), .la2_valid(la2_valid),
        .la2_warp(la2_warp), .busy_now(busy_now), .busy_nx1(busy_nx1),
        .busy_nx2(busy_nx2), .lane_wake(lane_wake)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic find_next(input logic [W-1:0] rdy, input int st, output bit v, output int ix);
        v = 0; ix = 0;
        for (int k = 0; k < W; k++) begin
            if (!v && rdy[(st + k) % W]) begin
                v = 1; ix = (st + k) % W;
            end
        end
    endtask

    // check all outputs against the model, then let one clock edge pass
    task automatic step(string tag);
        bit v [3];
        int ix [3];
        logic [L-1:0] eb [3];
        logic [L-1:0] ew;
        int st;
        #1;
        st = mptr;
        for (int s = 0; s < 3; s++) begin
            find_next(warp_ready, st, v[s], ix[s]);
            st = (ix[s] + 1) % W;
            eb[s] = v[s] ? warp_mask[ix[s]*L +: L] : '0;
        end
        for (int l = 0; l < L; l++) begin
            int lead;
            lead = int'(lane_mode[2*l +: 2]);
            ew[l] = 1'b0;
            for (int d = 0; d < 3; d++) if (d < lead && eb[d][l]) ew[l] = 1'b1;
        end
        cmp(tag, "issue_valid", 64'(issue_valid), 64'(v[0]));
        cmp(tag, "issue_warp",  64'(issue_warp),  64'(ix[0]));
        cmp(tag, "la1_valid",   64'(la1_valid),   64'(v[1]));
        cmp(tag, "la1_warp",    64'(la1_warp),    64'(ix[1]));
        cmp(tag, "la2_valid",   64'(la2_valid),   64'(v[2]));
        cmp(tag, "la2_warp",    64'(la2_warp),    64'(ix[2]));
        cmp(tag, "busy_now",    64'(busy_now),    64'(eb[0]));
        cmp(tag, "busy_nx1",    64'(busy_nx1),    64'(eb[1]));
        cmp(tag, "busy_nx2",    64'(busy_nx2),    64'(eb[2]));
        cmp(tag, "lane_wake",   64'(lane_wake),   64'(ew));
        if (v[0] && !rst) mptr = (ix[0] + 1) % W;
        @(negedge clk);
    endtask

    task automatic t_reset();
        warp_ready = '1;
        step("R1 first issue after reset");
        warp_ready = 8'b1100_0000;
        step("R1 pointer not at 7");
    endtask

    task automatic t_round_robin();
        warp_ready = 8'b1010_0110;
        for (int c = 0; c < 10; c++) step("R2 circular order with wrap");
    endtask

    task automatic t_single();
        warp_ready = 8'b0010_0000;
        for (int c = 0; c < 3; c++) step("R4 single ready warp fills window");
    endtask

    task automatic t_none();
        warp_ready = '0;
        lane_mode = {L{2'd3}};
        for (int c = 0; c < 2; c++) step("R3 no ready warp");
        lane_mode = '0;
    endtask

    task automatic t_masks();
        warp_ready = 8'b0000_1111;
        for (int c = 0; c < 6; c++) step("R5 busy masks follow active masks");
    endtask

    task automatic t_wake();
        for (int l = 0; l < L; l++) lane_mode[2*l +: 2] = 2'(l % 4);
        warp_ready = 8'b1111_1011;
        for (int c = 0; c < 8; c++) step("R7 wake lead per mode");
        for (int l = 0; l < L; l++) lane_mode[2*l +: 2] = 2'((l / 4) % 4);
        for (int c = 0; c < 4; c++) step("R6 mode field decode");
    endtask

    task automatic t_change();
        warp_ready = 8'b0001_0001;
        step("R8 set A");
        warp_ready = 8'b1110_0000;
        step("R8 set B");
        warp_ready = 8'b0000_0110;
        step("R8 set C");
        step("R8 set C again");
    endtask

    initial begin
        rst = 1'b1;
        warp_ready = '0;
        lane_mode = '0;
        for (int w = 0; w < W; w++)
            warp_mask[w*L +: L] = 32'hA5C3_0F01 ^ (32'h1 << (w * 4)) ^ (32'(w) << 20);
        warp_mask[2*L +: L] = '0;
        warp_mask[6*L +: L] = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        mptr = 0;
        step("R1 during reset");
        rst = 1'b0;
        mptr = 0;
        t_reset();
        t_round_robin();
        t_single();
        t_none();
        t_masks();
        t_wake();
        t_change();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule